// File: doc/BRIEF.md
# Backlight PWM Generator with Double-Buffered Configuration

A single-channel pulse-width generator for backlight dimming, programmed through a small register port with synchronous read and write strobes and a 32-bit data bus. A clock prescaler slows the input clock into PWM ticks. Each output cycle is a whole number of ticks, and the output is high for a programmed number of ticks at the start of each cycle.

Software writes the prescaler, period and high width into shadow registers. The working registers that drive the counters load from the shadows only when a commit is requested, and the load waits for the end of the output cycle in progress. A bypass setting turns double buffering off, so that configuration writes reach the working registers on the next clock.

Top module: `bklt_pwm`

## Requirements
- R1: A synchronous active-low reset clears every register and counter. After reset the output is low and every register reads zero.
- R2: Register map. Offset 0x00 holds the enable in bit 0. Offset 0x08 holds the commit bit in bit 0. Offset 0x0C holds the bypass field in bits [1:0]. Offset 0x10 holds the 10-bit prescaler in bits [25:16]. Offset 0x14 holds the 12-bit period in bits [11:0] and the 13-bit high width in bits [28:16]. A read returns the programmed (shadow) values one clock after rd_en. Unused bits and unmapped offsets read zero.
- R3: A tick lasts (prescaler+1) clocks. An output cycle lasts (period+1) ticks. The output is high for the first high_width ticks of each cycle and low for the rest.
- R4: While the enable bit is clear, the output is low.
- R5: When enable rises, the prescaler and cycle counters start from zero, and the output begins in the high phase (provided high width is nonzero).
- R6: Configuration writes with bypass off do not change the output until a commit is requested. A commit request is a write of 1 and then a write of 0 to commit bit 0.
- R7: With the output enabled, a commit is applied at the next output cycle boundary, so the cycle in progress keeps its old settings. With the output disabled, a commit is applied on the following clock.
- R8: With the bypass field equal to 2'b11, writes to 0x10 and 0x14 reach the working registers on the next clock, and no commit is needed.
- R9: If high width is greater than period, the output stays high for the whole cycle. If high width is 0, the output stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 8 | Register byte offset |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, valid one clock after rd_en |
| pwm_out | output | 1 | PWM output |

## Verification
The hardest case to reach is a commit that arrives partway through an enabled output cycle. The old settings must hold until the cycle boundary, and the new ones must take over exactly at the next cycle. The bench enables the output with known settings, counts clocks from the enabling edge, and then issues the two commit writes at a known tick inside the cycle. This fixes the clock on which the switch must appear. A sweep over small prescaler, period and high-width values, with and without bypass, checks every sample of the waveform against a pattern computed from the tick index. The sweep covers the zero and over-range high widths.

// File: rtl/bklt_pwm.sv
module bklt_pwm #(
  parameter int PSC_W = 10,
  parameter int PER_W = 12,
  parameter int HI_W  = 13,
  parameter int AW    = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic [AW-1:0] addr,
  input  logic [31:0]   wdata,
  output logic [31:0]   rdata,
  output logic          pwm_out
);
  localparam logic [AW-1:0] A_EN  = AW'(8'h00);
  localparam logic [AW-1:0] A_CMT = AW'(8'h08);
  localparam logic [AW-1:0] A_BYP = AW'(8'h0C);
  localparam logic [AW-1:0] A_PSC = AW'(8'h10);
  localparam logic [AW-1:0] A_PH  = AW'(8'h14);

  logic             en_r, cmt_r, pend;
  logic [1:0]       byp_r;
  logic [PSC_W-1:0] s_psc, w_psc, pcnt;
  logic [PER_W-1:0] s_per, w_per, ccnt;
  logic [HI_W-1:0]  s_hi, w_hi;

  wire bypass    = byp_r == 2'b11;
  wire wr_psc    = wr_en && addr == A_PSC;
  wire wr_ph     = wr_en && addr == A_PH;
  wire wr_cmt    = wr_en && addr == A_CMT;
  wire tick      = pcnt >= w_psc;
  wire end_cycle = tick && ccnt >= w_per;
  wire apply     = pend && (end_cycle || !en_r);

  assign pwm_out = en_r && (HI_W'(ccnt) < w_hi);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_r  <= 1'b0;
      cmt_r <= 1'b0;
      pend  <= 1'b0;
      byp_r <= '0;
      s_psc <= '0;
      s_per <= '0;
      s_hi  <= '0;
      w_psc <= '0;
      w_per <= '0;
      w_hi  <= '0;
      pcnt  <= '0;
      ccnt  <= '0;
      rdata <= '0;
    end else begin
      if (wr_en && addr == A_EN)  en_r  <= wdata[0];
      if (wr_en && addr == A_BYP) byp_r <= wdata[1:0];
      if (wr_cmt) cmt_r <= wdata[0];
      if (apply) pend <= 1'b0;
      if (wr_cmt && cmt_r && !wdata[0]) pend <= 1'b1;

      if (wr_psc) s_psc <= wdata[16 +: PSC_W];
      if (wr_ph) begin
        s_per <= wdata[0 +: PER_W];
        s_hi  <= wdata[16 +: HI_W];
      end

      if (apply) begin
        w_psc <= s_psc;
        w_per <= s_per;
        w_hi  <= s_hi;
      end
      if (bypass && wr_psc) w_psc <= wdata[16 +: PSC_W];
      if (bypass && wr_ph) begin
        w_per <= wdata[0 +: PER_W];
        w_hi  <= wdata[16 +: HI_W];
      end

      if (!en_r) begin
        pcnt <= '0;
        ccnt <= '0;
      end else if (tick) begin
        pcnt <= '0;
        ccnt <= end_cycle ? '0 : ccnt + 1'b1;
      end else begin
        pcnt <= pcnt + 1'b1;
      end

      if (rd_en) begin
        rdata <= '0;
        case (addr)
          A_EN:  rdata[0]            <= en_r;
          A_CMT: rdata[0]            <= cmt_r;
          A_BYP: rdata[1:0]          <= byp_r;
          A_PSC: rdata[16 +: PSC_W]  <= s_psc;
          A_PH: begin
            rdata[0 +: PER_W] <= s_per;
            rdata[16 +: HI_W] <= s_hi;
          end
          default: ;
        endcase
      end
    end
  end
endmodule

module bklt_pwm_chk #(
  parameter int PSC_W = 10,
  parameter int PER_W = 12,
  parameter int HI_W  = 13
) (
  input logic             clk,
  input logic             rst_n,
  input logic             en,
  input logic             pwm_out,
  input logic             bypass,
  input logic             end_cycle,
  input logic [PSC_W-1:0] pcnt,
  input logic [PER_W-1:0] ccnt,
  input logic [PSC_W-1:0] w_psc,
  input logic [PER_W-1:0] w_per,
  input logic [HI_W-1:0]  w_hi
);
  // R1
  reset_low_chk: assert property (@(posedge clk) !rst_n |=> !pwm_out);
  // R4
  disabled_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> !pwm_out);
  // R9
  zero_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (w_hi == '0) |-> !pwm_out);
  // R5
  restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(en) |-> (pcnt == '0 && ccnt == '0));
  // R7
  hold_mid_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !end_cycle && !bypass) |=>
      ($stable(w_psc) && $stable(w_per) && $stable(w_hi)));
endmodule

bind bklt_pwm bklt_pwm_chk #(.PSC_W(PSC_W), .PER_W(PER_W), .HI_W(HI_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .en(en_r), .pwm_out(pwm_out), .bypass(bypass),
  .end_cycle(end_cycle), .pcnt(pcnt), .ccnt(ccnt), .w_psc(w_psc),
  .w_per(w_per), .w_hi(w_hi));

// File: tb/bklt_pwm_test.sv
`timescale 1ns/1ps
module bklt_pwm_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        pwm_out;
  int total = 0, bad = 0;

  bklt_pwm uut (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .pwm_out(pwm_out));

  always #5 clk = ~clk;

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // called at a negedge, returns at the next negedge
  task automatic wr(logic [7:0] a, logic [31:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    d = rdata;
  endtask

  task automatic run_cfg(int psc, int per, int hi, bit byp);
    int n, miss;
    n = (psc + 1) * (per + 1);
    miss = 0;
    wr(8'h10, psc << 16);
    wr(8'h14, (hi << 16) | per);
    if (!byp) begin
      wr(8'h08, 1);
      wr(8'h08, 0);
      @(negedge clk);
    end
    wr(8'h00, 1);
    for (int i = 0; i < 2 * n; i++) begin
      if (pwm_out !== (((i % n) / (psc + 1)) < hi)) miss++;
      @(negedge clk);
    end
    // R3 R5 R9 (R8 when byp)
    check(byp ? "R8 R3 waveform" : "R3 R5 R9 waveform", miss, 0);
    wr(8'h00, 0);
    check("R4 disabled low", pwm_out, 0);
  endtask

  initial begin
    #1000000;
    bad++; total++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] d;
    int miss;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 out after reset", pwm_out, 0);
    rd(8'h10, d); check("R1 prescaler reset", d, 0);
    rd(8'h14, d); check("R1 period/high reset", d, 0);
    rd(8'h00, d); check("R1 enable reset", d, 0);

    // R2 readback and field masks
    wr(8'h10, 32'hFFFF_FFFF); rd(8'h10, d); check("R2 prescaler field", d, 32'h03FF_0000);
    wr(8'h14, 32'hFFFF_FFFF); rd(8'h14, d); check("R2 period/high fields", d, 32'h1FFF_0FFF);
    wr(8'h0C, 32'hFFFF_FFFC); rd(8'h0C, d); check("R2 bypass field", d, 0);
    wr(8'h08, 32'hFFFF_FFFF); rd(8'h08, d); check("R2 commit field", d, 1);
    wr(8'h08, 0);
    rd(8'h04, d); check("R2 unmapped offset", d, 0);
    wr(8'h00, 32'hFFFF_FFFF); rd(8'h00, d); check("R2 enable field", d, 1);
    wr(8'h00, 0); rd(8'h00, d); check("R2 enable cleared", d, 0);

    // R3 R9 sweep through shadow plus commit
    for (int p = 0; p < 3; p++)
      for (int q = 0; q < 4; q++)
        for (int h = 0; h < 6; h++)
          run_cfg(p, q, h, 1'b0);

    // R8 sweep in bypass
    wr(8'h0C, 3);
    for (int p = 0; p < 2; p++)
      for (int q = 0; q < 4; q++)
        for (int h = 0; h < 6; h++)
          run_cfg(p, q, h, 1'b1);
    wr(8'h0C, 0);

    // R6: shadow write with no commit leaves the output unchanged
    run_cfg(0, 9, 3, 1'b0);
    wr(8'h14, (7 << 16) | 9);
    wr(8'h00, 1);
    miss = 0;
    for (int i = 0; i < 20; i++) begin
      if (pwm_out !== ((i % 10) < 3)) miss++;
      @(negedge clk);
    end
    check("R6 no commit keeps old", miss, 0);
    wr(8'h00, 0);

    // R7: commit mid-cycle applies at the next boundary
    wr(8'h00, 1);
    miss = 0;
    for (int i = 0; i < 4; i++) begin
      if (pwm_out !== (i < 3)) miss++;
      @(negedge clk);
    end
    wr(8'h08, 1);
    wr(8'h08, 0);
    for (int j = 6; j < 30; j++) begin
      if (pwm_out !== (j < 10 ? 1'b0 : ((j - 10) % 10) < 7)) miss++;
      @(negedge clk);
    end
    check("R7 commit at boundary", miss, 0);
    wr(8'h00, 0);
    repeat (3) @(negedge clk);
    check("R4 stays low", pwm_out, 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule